// File: doc/BRIEF.md
# UART Status Flag Register

This block keeps the status flags of a serial port and drives its single interrupt request. The transmit and receive datapaths and the line monitors send it one-cycle event pulses:
- a word has moved into the transmit shifter
- a frame has finished
- a received word is ready
- a break was seen
- the line went idle
- overrun, noise, framing or parity trouble was found

It also watches the clear-to-send input for toggles while flow control is on. Each event sets its flag.

Software sees the flags through a status word that is read combinationally on `rdData`. Four one-cycle access strobes tell the block when software touches the status register or the data register. These accesses clear flags as a side effect. Some flags clear on a plain data access, some on a status read followed by a data access, and some only when software writes 0 to the flag. The interrupt request combines five of the flags with their enable inputs. The shifters, baud generator and control registers sit outside the block and reach it as plain inputs.

Top module: `uart_flag_reg`

## Requirements
- R1: After reset the status word reads 0x00C0: transmit-empty (bit 7) and transmit-complete (bit 6) are set, every other flag is clear, and bits above 9 read 0.
- R2: Transmit-empty (bit 7) is set by `evTxMove` and cleared by any data-register write; status writes never change it.
- R3: Transmit-complete (bit 6) is set by `evFrameDone` only in a cycle where transmit-empty is already set.
- R4: Transmit-complete is cleared by a data-register write that directly follows a status read, or by a status write with bit 6 at 0; a data write with no status read before it leaves it set.
- R5: Receive-ready (bit 5) is set by `evRxReady` and cleared by any data-register read or by a status write with bit 5 at 0.
- R6: The clear-to-send flag (bit 9) is set when `ctsIn` differs from its level in the previous cycle, only while `ctsFlowEn` is high. Only a status write with bit 9 at 0 clears it; data accesses do not. The sampled level starts high after reset.
- R7: The break flag (bit 8) is set by `evBreak` and cleared only by a status write with bit 8 at 0.
- R8: Idle (bit 4), overrun (bit 3), noise (bit 2), framing (bit 1) and parity (bit 0) are set by their event pulses. They are cleared together by a data-register read that directly follows a status read.
- R9: A status write leaves unchanged every flag whose write bit is 1. It also leaves unchanged bits 7 and 4..0, whatever is written to them.
- R10: When a set event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R11: A status read arms the two-step clears; any status write, data read or data write disarms them, so only the access right after the status read can complete a sequence.
- R12: `irq` is high exactly when at least one of the pairs is set: clear-to-send flag with `ieCts`, break flag with `ieBreak`, transmit-empty with `ieTxEmpty`, transmit-complete with `ieTxDone`, receive-ready with `ieRxReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| statusRd | input | 1 | One-cycle strobe: status register read |
| statusWr | input | 1 | One-cycle strobe: status register write |
| dataRd | input | 1 | One-cycle strobe: data register read |
| dataWr | input | 1 | One-cycle strobe: data register write |
| wrData | input | FLAG_N (10) | Write value for a status write |
| rdData | output | BUS_W (32) | Status word, zero-extended |
| evTxMove | input | 1 | Transmit word moved into the shifter |
| evFrameDone | input | 1 | Transmit frame finished |
| evRxReady | input | 1 | Received word placed in the data register |
| ctsIn | input | 1 | Clear-to-send line level |
| ctsFlowEn | input | 1 | Clear-to-send flow control enabled |
| evBreak | input | 1 | Line break detected |
| evIdle | input | 1 | Idle line detected |
| evOverrun | input | 1 | Receive overrun |
| evNoise | input | 1 | Noise detected |
| evFraming | input | 1 | Framing error |
| evParity | input | 1 | Parity error |
| ieCts | input | 1 | Interrupt enable, clear-to-send flag |
| ieBreak | input | 1 | Interrupt enable, break flag |
| ieTxEmpty | input | 1 | Interrupt enable, transmit-empty |
| ieTxDone | input | 1 | Interrupt enable, transmit-complete |
| ieRxReady | input | 1 | Interrupt enable, receive-ready |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check some rules on every cycle:
- a data write with no competing set empties the transmit flag
- a data read with no competing set empties receive-ready
- transmit-complete only rises while transmit-empty was set
- the clear-to-send flag only rises while flow control was on
- transmit-complete only falls after a sequence clear or a status write
- a break pulse always leaves the break flag set
- a non-status-read access always disarms the sequence

Only the directed scenarios show the rest, because it depends on the order of accesses:
- a status read must come right before the completing data access
- a sequence can be cancelled by another access in between
- writing 1 has no effect, and read-only bits ignore writes
- the exact status-word values and the interrupt combinations

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int FLAG_N = 10;

  // Bit positions within the status word
  localparam int PAR_B  = 0;
  localparam int FRM_B  = 1;
  localparam int NOI_B  = 2;
  localparam int OVR_B  = 3;
  localparam int IDL_B  = 4;
  localparam int RXR_B  = 5;
  localparam int TXD_B  = 6;
  localparam int TXE_B  = 7;
  localparam int BRK_B  = 8;
  localparam int CTS_B  = 9;

  localparam logic [FLAG_N-1:0] RESET_FLAGS = 10'h0C0;
  // Flags software may clear by writing 0
  localparam logic [FLAG_N-1:0] W0C_MASK = (10'b1 << CTS_B) | (10'b1 << BRK_B) |
                                           (10'b1 << TXD_B) | (10'b1 << RXR_B);
  // Flags cleared by status-read then data-read
  localparam logic [FLAG_N-1:0] ERR_MASK = 10'h01F;

  // Clear strobes from control to datapath
  typedef struct packed {
    logic wrStatus;   // status write this cycle
    logic txClr;      // any data write
    logic tcSeqClr;   // armed data write
    logic rxClr;      // any data read
    logic errSeqClr;  // armed data read
  } flagStrb_t;
endpackage

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      statusRd,
  input  logic      statusWr,
  input  logic      dataRd,
  input  logic      dataWr,
  output flagStrb_t strb
);
  logic armed;
  logic otherAcc;

  assign otherAcc = statusWr | dataRd | dataWr;

  // A status read arms; any other access consumes or cancels the arm.
  always_ff @(posedge clk) begin
    if (!rstN)         armed <= 1'b0;
    else if (statusRd) armed <= 1'b1;
    else if (otherAcc) armed <= 1'b0;
  end

  always_comb begin
    strb.wrStatus  = statusWr;
    strb.txClr     = dataWr;
    strb.tcSeqClr  = dataWr & armed;
    strb.rxClr     = dataRd;
    strb.errSeqClr = dataRd & armed;
  end

  // R11: an access other than a status read leaves the sequence disarmed
  p_disarm_r11: assert property (@(posedge clk) disable iff (!rstN)
    (otherAcc && !statusRd) |=> !armed);
endmodule

// File: rtl/uart_flag_datapath.sv
module uart_flag_datapath
  import uart_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrb_t         strb,
  input  logic [FLAG_N-1:0] wrMask,
  input  logic              evTxMove,
  input  logic              evFrameDone,
  input  logic              evRxReady,
  input  logic              ctsIn,
  input  logic              ctsFlowEn,
  input  logic              evBreak,
  input  logic              evIdle,
  input  logic              evOverrun,
  input  logic              evNoise,
  input  logic              evFraming,
  input  logic              evParity,
  input  logic [FLAG_N-1:0] ieVec,
  output logic [FLAG_N-1:0] flags,
  output logic              irq
);
  logic              ctsPrev;
  logic              ctsToggle;
  logic [FLAG_N-1:0] setVec;
  logic [FLAG_N-1:0] clrVec;
  logic [FLAG_N-1:0] w0cClr;

  always_ff @(posedge clk) begin
    if (!rstN) ctsPrev <= 1'b1;
    else       ctsPrev <= ctsIn;
  end

  assign ctsToggle = ctsFlowEn & (ctsIn ^ ctsPrev);
  assign w0cClr    = {FLAG_N{strb.wrStatus}} & ~wrMask & W0C_MASK;

  always_comb begin
    setVec         = '0;
    setVec[PAR_B]  = evParity;
    setVec[FRM_B]  = evFraming;
    setVec[NOI_B]  = evNoise;
    setVec[OVR_B]  = evOverrun;
    setVec[IDL_B]  = evIdle;
    setVec[RXR_B]  = evRxReady;
    setVec[TXD_B]  = evFrameDone & flags[TXE_B];
    setVec[TXE_B]  = evTxMove;
    setVec[BRK_B]  = evBreak;
    setVec[CTS_B]  = ctsToggle;

    clrVec         = w0cClr | ({FLAG_N{strb.errSeqClr}} & ERR_MASK);
    clrVec[TXE_B]  = strb.txClr;
    clrVec[TXD_B]  = w0cClr[TXD_B] | strb.tcSeqClr;
    clrVec[RXR_B]  = w0cClr[RXR_B] | strb.rxClr;
  end

  // One set-dominant flop per flag
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)          flags[i] <= RESET_FLAGS[i];
      else if (setVec[i]) flags[i] <= 1'b1;
      else if (clrVec[i]) flags[i] <= 1'b0;
    end
  end

  assign irq = |(flags & ieVec);

  // R2: a data write with no competing set empties transmit-empty
  p_txe_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txClr && !evTxMove) |=> !flags[TXE_B]);
  // R3: transmit-complete rises only while transmit-empty was set
  p_tc_guard_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[TXD_B]) |-> $past(flags[TXE_B]));
  // R4: transmit-complete falls only after a sequence clear or status write
  p_tc_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flags[TXD_B]) |-> $past(strb.tcSeqClr || strb.wrStatus));
  // R5: a data read with no competing set empties receive-ready
  p_rx_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxClr && !evRxReady) |=> !flags[RXR_B]);
  // R6: the clear-to-send flag rises only while flow control was on
  p_cts_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[CTS_B]) |-> $past(ctsFlowEn));
  // R10: a break pulse wins over any same-cycle clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    evBreak |=> flags[BRK_B]);
endmodule

// File: rtl/uart_flag_reg.sv
module uart_flag_reg
  import uart_flag_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              statusRd,
  input  logic              statusWr,
  input  logic              dataRd,
  input  logic              dataWr,
  input  logic [FLAG_N-1:0] wrData,
  output logic [BUS_W-1:0]  rdData,
  input  logic              evTxMove,
  input  logic              evFrameDone,
  input  logic              evRxReady,
  input  logic              ctsIn,
  input  logic              ctsFlowEn,
  input  logic              evBreak,
  input  logic              evIdle,
  input  logic              evOverrun,
  input  logic              evNoise,
  input  logic              evFraming,
  input  logic              evParity,
  input  logic              ieCts,
  input  logic              ieBreak,
  input  logic              ieTxEmpty,
  input  logic              ieTxDone,
  input  logic              ieRxReady,
  output logic              irq
);
  localparam int PAD_W = BUS_W - FLAG_N;

  flagStrb_t         strb;
  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] ieVec;

  always_comb begin
    ieVec        = '0;
    ieVec[CTS_B] = ieCts;
    ieVec[BRK_B] = ieBreak;
    ieVec[TXE_B] = ieTxEmpty;
    ieVec[TXD_B] = ieTxDone;
    ieVec[RXR_B] = ieRxReady;
  end

  uart_flag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .statusRd(statusRd), .statusWr(statusWr),
    .dataRd(dataRd), .dataWr(dataWr), .strb(strb)
  );

  uart_flag_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrMask(wrData),
    .evTxMove(evTxMove), .evFrameDone(evFrameDone), .evRxReady(evRxReady),
    .ctsIn(ctsIn), .ctsFlowEn(ctsFlowEn), .evBreak(evBreak), .evIdle(evIdle),
    .evOverrun(evOverrun), .evNoise(evNoise), .evFraming(evFraming),
    .evParity(evParity), .ieVec(ieVec), .flags(flags), .irq(irq)
  );

  assign rdData = {{PAD_W{1'b0}}, flags};
endmodule

// File: tb/uart_flag_reg_bench.sv
module uart_flag_reg_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic statusRd = 0, statusWr = 0, dataRd = 0, dataWr = 0;
  logic [9:0] wrData = '0;
  logic [31:0] rdData;
  logic evTxMove = 0, evFrameDone = 0, evRxReady = 0, ctsIn = 1, ctsFlowEn = 0;
  logic evBreak = 0, evIdle = 0, evOverrun = 0, evNoise = 0, evFraming = 0, evParity = 0;
  logic ieCts = 0, ieBreak = 0, ieTxEmpty = 0, ieTxDone = 0, ieRxReady = 0;
  logic irq;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  uart_flag_reg u_uart_flag_reg (
    .clk(clk), .rstN(rstN), .statusRd(statusRd), .statusWr(statusWr),
    .dataRd(dataRd), .dataWr(dataWr), .wrData(wrData), .rdData(rdData),
    .evTxMove(evTxMove), .evFrameDone(evFrameDone), .evRxReady(evRxReady),
    .ctsIn(ctsIn), .ctsFlowEn(ctsFlowEn), .evBreak(evBreak), .evIdle(evIdle),
    .evOverrun(evOverrun), .evNoise(evNoise), .evFraming(evFraming),
    .evParity(evParity), .ieCts(ieCts), .ieBreak(ieBreak), .ieTxEmpty(ieTxEmpty),
    .ieTxDone(ieTxDone), .ieRxReady(ieRxReady), .irq(irq)
  );

  // acc = {statusRd, statusWr, dataRd, dataWr}
  // ev  = {break, txMove, frameDone, rxReady, idle, overrun, noise, framing, parity}
  task automatic apply(input logic [3:0] acc, input logic [9:0] wd, input logic [8:0] ev);
    {statusRd, statusWr, dataRd, dataWr} = acc;
    wrData = wd;
    {evBreak, evTxMove, evFrameDone, evRxReady, evIdle, evOverrun, evNoise,
     evFraming, evParity} = ev;
    @(negedge clk);
    {statusRd, statusWr, dataRd, dataWr} = '0;
    wrData = '0;
    {evBreak, evTxMove, evFrameDone, evRxReady, evIdle, evOverrun, evNoise,
     evFraming, evParity} = '0;
  endtask

  task automatic checkWord(input string req, input logic [31:0] exp);
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s status actual=%h expected=%h", req, rdData, exp);
    end
  endtask

  task automatic checkIrq(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
    end
  endtask

  localparam logic [3:0] SRD = 4'b1000, SWR = 4'b0100, DRD = 4'b0010, DWR = 4'b0001;

  task automatic t_reset;
    checkWord("R1", 32'h0C0);
    checkIrq("R1", 1'b0);
  endtask

  task automatic t_txEmpty;
    apply(SWR, 10'h3FF, 9'h0);  checkWord("R9", 32'h0C0);
    apply(DWR, 10'h0, 9'h0);    checkWord("R2", 32'h040);
    apply(SWR, 10'h3FF, 9'h0);  checkWord("R2", 32'h040);
    apply(4'b0, 10'h0, 9'h080); checkWord("R2", 32'h0C0);
  endtask

  task automatic t_txDone;
    apply(DWR, 10'h0, 9'h0);    checkWord("R2", 32'h040);
    apply(SWR, 10'h0, 9'h0);    checkWord("R4", 32'h000);
    apply(4'b0, 10'h0, 9'h040); checkWord("R3", 32'h000);
    apply(4'b0, 10'h0, 9'h080); checkWord("R3", 32'h080);
    apply(4'b0, 10'h0, 9'h040); checkWord("R3", 32'h0C0);
  endtask

  task automatic t_tcSequence;
    apply(SRD, 10'h0, 9'h0);    checkWord("R4", 32'h0C0);
    apply(DWR, 10'h0, 9'h0);    checkWord("R4", 32'h000);
    apply(4'b0, 10'h0, 9'h080);
    apply(4'b0, 10'h0, 9'h040); checkWord("R4", 32'h0C0);
    apply(DWR, 10'h0, 9'h0);    checkWord("R4", 32'h040);
    apply(4'b0, 10'h0, 9'h080); checkWord("R2", 32'h0C0);
  endtask

  task automatic t_cancel;
    apply(SRD, 10'h0, 9'h0);
    apply(DRD, 10'h0, 9'h0);
    apply(DWR, 10'h0, 9'h0);    checkWord("R11", 32'h040);
    apply(4'b0, 10'h0, 9'h080); checkWord("R11", 32'h0C0);
  endtask

  task automatic t_rxReady;
    apply(4'b0, 10'h0, 9'h020);   checkWord("R5", 32'h0E0);
    apply(DRD, 10'h0, 9'h0);      checkWord("R5", 32'h0C0);
    apply(4'b0, 10'h0, 9'h020);   checkWord("R5", 32'h0E0);
    apply(SWR, 10'h3DF, 9'h0);    checkWord("R5", 32'h0C0);
  endtask

  task automatic t_cts;
    ctsFlowEn = 1'b0; ctsIn = 1'b0;
    @(negedge clk); @(negedge clk); checkWord("R6", 32'h0C0);
    ctsFlowEn = 1'b1; ctsIn = 1'b1;
    @(negedge clk); @(negedge clk); checkWord("R6", 32'h2C0);
    apply(DRD, 10'h0, 9'h0);      checkWord("R6", 32'h2C0);
    apply(SWR, 10'h3FF, 9'h0);    checkWord("R9", 32'h2C0);
    apply(SWR, 10'h1FF, 9'h0);    checkWord("R6", 32'h0C0);
    ctsFlowEn = 1'b0;
  endtask

  task automatic t_break;
    apply(4'b0, 10'h0, 9'h100);   checkWord("R7", 32'h1C0);
    apply(DWR, 10'h0, 9'h0);      checkWord("R7", 32'h140);
    apply(SWR, 10'h2FF, 9'h0);    checkWord("R7", 32'h040);
  endtask

  task automatic t_errors;
    apply(4'b0, 10'h0, 9'h01F);   checkWord("R8", 32'h05F);
    apply(SWR, 10'h0, 9'h0);      checkWord("R9", 32'h01F);
    apply(DRD, 10'h0, 9'h0);      checkWord("R8", 32'h01F);
    apply(SRD, 10'h0, 9'h0);
    apply(DRD, 10'h0, 9'h0);      checkWord("R8", 32'h000);
  endtask

  task automatic t_setWins;
    apply(SWR, 10'h0, 9'h100);    checkWord("R10", 32'h100);
    apply(DRD, 10'h0, 9'h020);    checkWord("R10", 32'h120);
    apply(SWR, 10'h0DF, 9'h0);    checkWord("R10", 32'h000);
  endtask

  task automatic t_irq;
    checkIrq("R12", 1'b0);
    ieRxReady = 1'b1;
    apply(4'b0, 10'h0, 9'h020);   checkIrq("R12", 1'b1);
    ieRxReady = 1'b0; #1;         checkIrq("R12", 1'b0);
    ieTxEmpty = 1'b1; ieTxDone = 1'b1; ieBreak = 1'b1; ieCts = 1'b1; #1;
    checkIrq("R12", 1'b0);
    apply(4'b0, 10'h0, 9'h080);   checkIrq("R12", 1'b1);
    apply(DWR, 10'h0, 9'h0);      checkIrq("R12", 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_txEmpty();
    t_txDone();
    t_tcSequence();
    t_cancel();
    t_rxReady();
    t_cts();
    t_break();
    t_errors();
    t_setWins();
    t_irq();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule